// File: doc/BRIEF.md
# Hardwired Control-Step Sequencer

This block is the control unit of a 32-bit datapath built around one shared bus. A step counter, together with the 5-bit operation code taken from the top of the instruction register, selects one control word per clock cycle. The word carries the strobes that put a register on the bus or load it from the bus. It also carries the general-register field selects, the ALU function, memory read and write requests, a wait request and an end-of-instruction flag. Every instruction starts with the same three fetch steps. Execution begins at step 3 and follows a sequence that depends on the operation code.

The datapath feeds back four things: the memory-complete handshake, the run flag, the result of the branch condition test, and a flag that is high when the shift counter is zero. A step that asserts wait freezes the counter until memory completes. The shift step loops on itself, decrementing the counter, until the count reaches zero. The end flag returns the counter to step 0, where the next fetch begins if run is still set.

The control word has the packed layout `ctl_word_t` from `ctlseq_pkg`. A strobe that a requirement does not name is low in that step.

Top module: `ctl_sequencer`

## Requirements
- R1: After a synchronous reset the step output is 0. While the step is 0 and run is low, the control word is all zero and the step stays 0.
- R2: Fetch works as follows. Step 0 gives pc_out, ma_in, c_in with alu=ALU_INC4. Step 1 gives mem_rd, c_out, pc_in, wait_mem. Step 2 gives md_out, ir_in. The next step is 3 for every operation code.
- R3: While the current word has wait_mem set and mem_done is low, the step and the word are held. In a word without wait_mem, a low mem_done has no effect and the step advances.
- R4: Add (opcode 12) runs three steps. Step 3 gives sel_rb, r_out, a_in. Step 4 gives sel_rc, r_out, c_in with alu=ALU_ADD. Step 5 gives c_out, sel_ra, r_in, done. Add-immediate (opcode 13) is identical, except that step 4 gives c2_out, c_in with alu=ALU_ADD.
- R5: Load (opcode 1) runs five steps. Step 3 gives sel_rb, base_out, a_in. Step 4 gives c2_out, c_in with alu=ALU_ADD. Step 5 gives c_out, ma_in. Step 6 gives mem_rd, wait_mem. Step 7 gives md_out, sel_ra, r_in, done.
- R6: Store (opcode 3) shares steps 3 to 5 with load. Step 6 gives sel_ra, r_out, md_in, mem_wr. Step 7 gives wait_mem, done.
- R7: Branch (opcode 8) runs two steps. Step 3 gives sel_rc, r_out, con_load. Step 4 gives sel_rb, r_out and done, plus pc_in only when cond_true is high.
- R8: Shift right (opcode 26) works as follows. Step 3 gives c1_out, cnt_load. Step 4 gives sel_rc, r_out, cnt_load if count_zero is high, and nothing otherwise. Step 5 gives sel_rb, r_out, c_in with alu=ALU_PASSB. Step 6 repeats, giving c_out, c_in, cnt_dec with alu=ALU_SHR, while count_zero is low. Once count_zero is high, step 6 gives an empty word and moves on. Step 7 gives c_out, sel_ra, r_in, done.
- R9: Opcode 0, and any opcode not listed above, gives a word with only done at step 3. Opcode 31 gives halt and done at step 3.
- R10: A word with done set that is not stalled sends the step to 0 on the next cycle.
- R11: In every cycle at most one of pc_out, c_out, md_out, r_out, base_out, c2_out, c1_out is high, and mem_rd and mem_wr are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Run flag from the datapath; lets step 0 begin a fetch |
| opcode | input | 5 | Operation code, the top five bits of the instruction register |
| mem_done | input | 1 | Memory-complete handshake |
| cond_true | input | 1 | Result of the branch condition test |
| count_zero | input | 1 | High when the shift counter is zero |
| step | output | STEP_W | Current control step |
| cw | output | CW_W | Control word for the current step (layout `ctl_word_t`) |

## Verification
The control word is a combinational function of the current step and the inputs, so it is due in the same cycle that the inputs are applied. The step moves one clock edge later. The bench applies the inputs just after each falling edge, compares the word and the step shortly afterwards, and lets the rising edge that follows move its own step model. Stalls on the fetch read, the load read and the store completion last from zero to several cycles. The shift loop length comes from a count that the bench tracks itself, which fixes exactly which cycle the empty step-6 word must appear in.

// File: rtl/ctlseq_pkg.sv
package ctlseq_pkg;

    localparam int OP_W       = 5;
    localparam int MIN_STEP_W = 3;

    localparam logic [OP_W-1:0] OPC_NOP  = 5'd0;
    localparam logic [OP_W-1:0] OPC_LD   = 5'd1;
    localparam logic [OP_W-1:0] OPC_ST   = 5'd3;
    localparam logic [OP_W-1:0] OPC_BR   = 5'd8;
    localparam logic [OP_W-1:0] OPC_ADD  = 5'd12;
    localparam logic [OP_W-1:0] OPC_ADDI = 5'd13;
    localparam logic [OP_W-1:0] OPC_SHR  = 5'd26;
    localparam logic [OP_W-1:0] OPC_STOP = 5'd31;

    typedef enum logic [2:0] {
        ALU_NONE  = 3'd0,
        ALU_ADD   = 3'd1,
        ALU_INC4  = 3'd2,
        ALU_PASSB = 3'd3,
        ALU_SHR   = 3'd4
    } alu_fn_e;

    typedef struct packed {
        logic    pc_out;
        logic    pc_in;
        logic    ma_in;
        logic    md_out;
        logic    md_in;
        logic    ir_in;
        logic    a_in;
        logic    c_in;
        logic    c_out;
        logic    r_out;
        logic    r_in;
        logic    base_out;
        logic    c2_out;
        logic    c1_out;
        logic    sel_ra;
        logic    sel_rb;
        logic    sel_rc;
        logic    mem_rd;
        logic    mem_wr;
        logic    wait_mem;
        logic    done;
        logic    cnt_load;
        logic    cnt_dec;
        logic    con_load;
        logic    halt;
        alu_fn_e alu;
    } ctl_word_t;

    localparam int CW_W = $bits(ctl_word_t);

    // Gathers every strobe that drives the shared bus into one vector.
    function automatic logic [6:0] bus_drivers(input ctl_word_t w);
        return {w.pc_out, w.c_out, w.md_out, w.r_out, w.base_out, w.c2_out, w.c1_out};
    endfunction

endpackage

// File: rtl/step_ctr.sv
module step_ctr
    import ctlseq_pkg::*;
#(
    parameter int STEP_W = MIN_STEP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              stall,
    input  logic              done,
    input  logic              loop_here,
    output logic [STEP_W-1:0] step
);

    localparam logic [STEP_W-1:0] HOME = '0;
    localparam logic [STEP_W-1:0] LAST_FETCH = STEP_W'(2);
    localparam logic [STEP_W-1:0] FIRST_EXEC = STEP_W'(3);

    always_ff @(posedge clk) begin
        if (rst) begin
            step <= HOME;
        end else if (!active) begin
            step <= HOME;
        end else if (stall) begin
            step <= step;
        end else if (done) begin
            step <= HOME;
        end else if (loop_here) begin
            step <= step;
        end else begin
            step <= step + STEP_W'(1);
        end
    end

    a_r1_idle_home: assert property (@(posedge clk) disable iff (rst)
        !active |=> step == HOME);

    a_r3_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (active && stall) |=> $stable(step));

    a_r10_end_home: assert property (@(posedge clk) disable iff (rst)
        (active && done && !stall) |=> step == HOME);

    a_r8_loop_hold: assert property (@(posedge clk) disable iff (rst)
        (active && loop_here && !stall) |=> $stable(step));

    a_r2_fetch_to_exec: assert property (@(posedge clk) disable iff (rst)
        (active && step == LAST_FETCH && !stall && !done) |=> step == FIRST_EXEC);

endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
    import ctlseq_pkg::*;
#(
    parameter int STEP_W = MIN_STEP_W
) (
    input  logic [STEP_W-1:0] step,
    input  logic [OP_W-1:0]   opcode,
    input  logic              run,
    input  logic              cond_true,
    input  logic              count_zero,
    output ctl_word_t         cw,
    output logic              loop_here
);

    localparam logic [STEP_W-1:0] T0 = STEP_W'(0);
    localparam logic [STEP_W-1:0] T1 = STEP_W'(1);
    localparam logic [STEP_W-1:0] T2 = STEP_W'(2);
    localparam logic [STEP_W-1:0] T3 = STEP_W'(3);
    localparam logic [STEP_W-1:0] T4 = STEP_W'(4);
    localparam logic [STEP_W-1:0] T5 = STEP_W'(5);
    localparam logic [STEP_W-1:0] T6 = STEP_W'(6);
    localparam logic [STEP_W-1:0] T7 = STEP_W'(7);

    // Execution steps shared by the arithmetic group (add, addi).
    function automatic ctl_word_t arith_word(input logic [STEP_W-1:0] t, input logic imm);
        ctl_word_t w;
        w = '0;
        unique case (t)
            T3: begin w.sel_rb = 1'b1; w.r_out = 1'b1; w.a_in = 1'b1; end
            T4: begin
                if (imm) w.c2_out = 1'b1;
                else begin w.sel_rc = 1'b1; w.r_out = 1'b1; end
                w.alu = ALU_ADD; w.c_in = 1'b1;
            end
            T5: begin w.c_out = 1'b1; w.sel_ra = 1'b1; w.r_in = 1'b1; w.done = 1'b1; end
            default: w.done = 1'b1;
        endcase
        return w;
    endfunction

    // Execution steps for the memory group (ld, st); address steps shared.
    function automatic ctl_word_t mem_word(input logic [STEP_W-1:0] t, input logic is_store);
        ctl_word_t w;
        w = '0;
        unique case (t)
            T3: begin w.sel_rb = 1'b1; w.base_out = 1'b1; w.a_in = 1'b1; end
            T4: begin w.c2_out = 1'b1; w.alu = ALU_ADD; w.c_in = 1'b1; end
            T5: begin w.c_out = 1'b1; w.ma_in = 1'b1; end
            T6: begin
                if (is_store) begin
                    w.sel_ra = 1'b1; w.r_out = 1'b1; w.md_in = 1'b1; w.mem_wr = 1'b1;
                end else begin
                    w.mem_rd = 1'b1; w.wait_mem = 1'b1;
                end
            end
            T7: begin
                if (is_store) begin
                    w.wait_mem = 1'b1;
                end else begin
                    w.md_out = 1'b1; w.sel_ra = 1'b1; w.r_in = 1'b1;
                end
                w.done = 1'b1;
            end
            default: w.done = 1'b1;
        endcase
        return w;
    endfunction

    function automatic ctl_word_t branch_word(input logic [STEP_W-1:0] t, input logic take);
        ctl_word_t w;
        w = '0;
        unique case (t)
            T3: begin w.sel_rc = 1'b1; w.r_out = 1'b1; w.con_load = 1'b1; end
            T4: begin w.sel_rb = 1'b1; w.r_out = 1'b1; w.pc_in = take; w.done = 1'b1; end
            default: w.done = 1'b1;
        endcase
        return w;
    endfunction

    function automatic ctl_word_t shift_word(input logic [STEP_W-1:0] t, input logic cz);
        ctl_word_t w;
        w = '0;
        unique case (t)
            T3: begin w.c1_out = 1'b1; w.cnt_load = 1'b1; end
            T4: begin
                if (cz) begin w.sel_rc = 1'b1; w.r_out = 1'b1; w.cnt_load = 1'b1; end
            end
            T5: begin w.sel_rb = 1'b1; w.r_out = 1'b1; w.alu = ALU_PASSB; w.c_in = 1'b1; end
            T6: begin
                if (!cz) begin
                    w.c_out = 1'b1; w.alu = ALU_SHR; w.c_in = 1'b1; w.cnt_dec = 1'b1;
                end
            end
            T7: begin w.c_out = 1'b1; w.sel_ra = 1'b1; w.r_in = 1'b1; w.done = 1'b1; end
            default: w.done = 1'b1;
        endcase
        return w;
    endfunction

    ctl_word_t exec_w;

    always_comb begin
        exec_w = '0;
        unique case (opcode)
            OPC_ADD:  exec_w = arith_word(step, 1'b0);
            OPC_ADDI: exec_w = arith_word(step, 1'b1);
            OPC_LD:   exec_w = mem_word(step, 1'b0);
            OPC_ST:   exec_w = mem_word(step, 1'b1);
            OPC_BR:   exec_w = branch_word(step, cond_true);
            OPC_SHR:  exec_w = shift_word(step, count_zero);
            OPC_STOP: begin exec_w.halt = 1'b1; exec_w.done = 1'b1; end
            default:  exec_w.done = 1'b1;
        endcase
    end

    always_comb begin
        cw = '0;
        loop_here = 1'b0;
        unique case (step)
            T0: begin
                if (run) begin
                    cw.pc_out = 1'b1; cw.ma_in = 1'b1; cw.alu = ALU_INC4; cw.c_in = 1'b1;
                end
            end
            T1: begin
                cw.mem_rd = 1'b1; cw.c_out = 1'b1; cw.pc_in = 1'b1; cw.wait_mem = 1'b1;
            end
            T2: begin
                cw.md_out = 1'b1; cw.ir_in = 1'b1;
            end
            default: begin
                cw = exec_w;
                loop_here = (opcode == OPC_SHR) && (step == T6) && !count_zero;
            end
        endcase
    end

endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
    import ctlseq_pkg::*;
#(
    parameter int STEP_W = MIN_STEP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [OP_W-1:0]   opcode,
    input  logic              mem_done,
    input  logic              cond_true,
    input  logic              count_zero,
    output logic [STEP_W-1:0] step,
    output logic [CW_W-1:0]   cw
);

    ctl_word_t word;
    logic      loop_here;
    logic      active;
    logic      stall;

    assign active = run || (step != '0);
    assign stall  = word.wait_mem && !mem_done;
    assign cw     = word;

    ctl_decode #(.STEP_W(STEP_W)) dec_i (
        .step       (step),
        .opcode     (opcode),
        .run        (run),
        .cond_true  (cond_true),
        .count_zero (count_zero),
        .cw         (word),
        .loop_here  (loop_here)
    );

    step_ctr #(.STEP_W(STEP_W)) ctr_i (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .stall     (stall),
        .done      (word.done),
        .loop_here (loop_here),
        .step      (step)
    );

    a_r11_one_driver: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_drivers(word)));

    a_r11_rdwr_excl: assert property (@(posedge clk) disable iff (rst)
        !(word.mem_rd && word.mem_wr));

    a_r1_idle_word: assert property (@(posedge clk) disable iff (rst)
        (step == '0 && !run) |-> (cw == '0));

endmodule

// File: tb/ctl_sequencer_tb.sv
module ctl_sequencer_tb_top;
    import ctlseq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int STEP_W = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              run = 1'b0;
    logic [OP_W-1:0]   opcode = '0;
    logic              mem_done = 1'b0;
    logic              cond_true = 1'b0;
    logic              count_zero = 1'b0;
    logic [STEP_W-1:0] step;
    logic [CW_W-1:0]   cw;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // values applied at the next falling edge
    logic            cur_run = 1'b0;
    logic [OP_W-1:0] cur_op = '0;
    logic            cur_cond = 1'b0;
    logic            cur_cz = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_sequencer #(.STEP_W(STEP_W)) dut_i (
        .clk(clk), .rst(rst), .run(run), .opcode(opcode), .mem_done(mem_done),
        .cond_true(cond_true), .count_zero(count_zero), .step(step), .cw(cw)
    );

    task automatic cyc(input ctl_word_t e, input int s, input logic md, input string tag);
        ctl_word_t got;
        @(negedge clk);
        run = cur_run; opcode = cur_op; cond_true = cur_cond; count_zero = cur_cz;
        mem_done = md;
        #1;
        got = ctl_word_t'(cw);
        checks++;
        if (int'(step) != s) begin
            failures++;
            $display("FAIL %s step actual=%0d expected=%0d", tag, step, s);
        end
        checks++;
        if (got !== e) begin
            failures++;
            $display("FAIL %s word at step %0d actual=%h expected=%h", tag, s, got, e);
        end
    endtask

    task automatic wstep(input ctl_word_t e, input int s, input int stalls, input string tag);
        for (int i = 0; i < stalls; i++) cyc(e, s, 1'b0, tag);
        cyc(e, s, 1'b1, tag);
    endtask

    task automatic fetch(input int stalls);
        ctl_word_t e;
        e = '0; e.pc_out = 1; e.ma_in = 1; e.alu = ALU_INC4; e.c_in = 1;
        cyc(e, 0, 1'b0, "R2");
        e = '0; e.mem_rd = 1; e.c_out = 1; e.pc_in = 1; e.wait_mem = 1;
        wstep(e, 1, stalls, "R3");
        e = '0; e.md_out = 1; e.ir_in = 1;
        cyc(e, 2, 1'b0, "R2");
    endtask

    task automatic do_arith(input bit imm, input int fst);
        ctl_word_t e;
        cur_op = imm ? 5'd13 : 5'd12;
        fetch(fst);
        e = '0; e.sel_rb = 1; e.r_out = 1; e.a_in = 1;
        cyc(e, 3, 1'b0, "R4");
        e = '0; e.alu = ALU_ADD; e.c_in = 1;
        if (imm) e.c2_out = 1; else begin e.sel_rc = 1; e.r_out = 1; end
        cyc(e, 4, 1'b0, "R4");
        e = '0; e.c_out = 1; e.sel_ra = 1; e.r_in = 1; e.done = 1;
        cyc(e, 5, 1'b0, "R10");
    endtask

    task automatic do_mem(input bit store, input int fst, input int mst);
        ctl_word_t e;
        cur_op = store ? 5'd3 : 5'd1;
        fetch(fst);
        e = '0; e.sel_rb = 1; e.base_out = 1; e.a_in = 1;
        cyc(e, 3, 1'b0, store ? "R6" : "R5");
        e = '0; e.c2_out = 1; e.alu = ALU_ADD; e.c_in = 1;
        cyc(e, 4, 1'b0, store ? "R6" : "R5");
        e = '0; e.c_out = 1; e.ma_in = 1;
        cyc(e, 5, 1'b0, store ? "R6" : "R5");
        if (store) begin
            e = '0; e.sel_ra = 1; e.r_out = 1; e.md_in = 1; e.mem_wr = 1;
            cyc(e, 6, 1'b0, "R6");
            e = '0; e.wait_mem = 1; e.done = 1;
            wstep(e, 7, mst, "R6");
        end else begin
            e = '0; e.mem_rd = 1; e.wait_mem = 1;
            wstep(e, 6, mst, "R5");
            e = '0; e.md_out = 1; e.sel_ra = 1; e.r_in = 1; e.done = 1;
            cyc(e, 7, 1'b0, "R5");
        end
    endtask

    task automatic do_br(input bit take);
        ctl_word_t e;
        cur_op = 5'd8;
        cur_cond = take;
        fetch(0);
        e = '0; e.sel_rc = 1; e.r_out = 1; e.con_load = 1;
        cyc(e, 3, 1'b0, "R7");
        e = '0; e.sel_rb = 1; e.r_out = 1; e.pc_in = take; e.done = 1;
        cyc(e, 4, 1'b0, "R7");
        cur_cond = 1'b0;
    endtask

    // n models the datapath shift counter
    task automatic do_shr(input int imm_cnt, input int reg_cnt);
        ctl_word_t e;
        int n;
        cur_op = 5'd26;
        n = 0;
        cur_cz = 1'b1;
        fetch(0);
        e = '0; e.c1_out = 1; e.cnt_load = 1;
        cyc(e, 3, 1'b0, "R8");
        n = imm_cnt;
        cur_cz = (n == 0);
        e = '0;
        if (n == 0) begin e.sel_rc = 1; e.r_out = 1; e.cnt_load = 1; end
        cyc(e, 4, 1'b0, "R8");
        if (n == 0) n = reg_cnt;
        cur_cz = (n == 0);
        e = '0; e.sel_rb = 1; e.r_out = 1; e.alu = ALU_PASSB; e.c_in = 1;
        cyc(e, 5, 1'b0, "R8");
        while (n != 0) begin
            cur_cz = 1'b0;
            e = '0; e.c_out = 1; e.alu = ALU_SHR; e.c_in = 1; e.cnt_dec = 1;
            cyc(e, 6, 1'b0, "R8");
            n--;
        end
        cur_cz = 1'b1;
        cyc('0, 6, 1'b0, "R8");
        e = '0; e.c_out = 1; e.sel_ra = 1; e.r_in = 1; e.done = 1;
        cyc(e, 7, 1'b0, "R8");
    endtask

    task automatic do_simple(input logic [OP_W-1:0] op);
        ctl_word_t e;
        cur_op = op;
        fetch(0);
        e = '0; e.done = 1; e.halt = (op == 5'd31);
        cyc(e, 3, 1'b0, "R9");
    endtask

    task automatic idle(input int n);
        cur_run = 1'b0;
        for (int i = 0; i < n; i++) cyc('0, 0, 1'b1, "R1");
        cur_run = 1'b1;
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle(3);
        cur_run = 1'b1;
        do_arith(1'b0, 0);
        do_arith(1'b0, 3);
        do_arith(1'b1, 2);
        do_mem(1'b0, 1, 4);
        do_mem(1'b0, 0, 0);
        do_mem(1'b1, 0, 2);
        do_mem(1'b1, 5, 0);
        do_br(1'b1);
        do_br(1'b0);
        do_shr(3, 5);
        do_shr(0, 2);
        do_shr(0, 0);
        do_shr(1, 0);
        do_simple(5'd0);
        do_simple(5'd7);
        do_simple(5'd19);
        do_simple(5'd31);
        idle(4);
        do_arith(1'b0, 1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired at step %0d expected completion", step);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule